// File: doc/BRIEF.md
# Hardened Transmit Packet Buffer

This block holds outgoing messages for one traffic class of a link port until the output arbiter lets them onto the link. A producer hands in a message as a run of 16-bit words framed by a start strobe on the first word and an end strobe on the last. A stop strobe abandons the message in flight. While the words arrive, the write side keeps a running CRC-16. In the cycle after the end word it stores the checksum as a trailing word. The checksum therefore travels with the message from the moment it is stored.

Storage is a speculative FIFO. Words are written past a committed write pointer and become visible to the read side only when the whole message and its CRC are in. The read side also advances a tentative pointer and commits it only when the last word has left. A message that is aborted, overflowed or timed out on either side is therefore rolled back in one cycle, and no fragment is left behind. Each of the two state machines has its own watchdog, which returns it to idle when it stalls outside idle.

The read side raises a request as soon as at least one complete message is stored. A single-cycle grant starts the packet. From the next cycle the words stream out back to back with valid held high, and a last flag marks the CRC word.

Top module: `hardened_tx_buffer`

## Requirements
- R1: Out of reset, outReq and outValid are low and the buffer holds no message.
- R2: A delivered packet is the message words in input order, followed by one CRC word. The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, fed each word MSB first. outLast is high only on the CRC word.
- R3: outReq stays low while a message is still being written and no earlier message is complete. It rises within three cycles after the end word once the message is stored.
- R4: When outGrant is high in a cycle with outReq high, outValid is high from the next cycle on, in consecutive cycles, until the last word. outValid falls in the cycle after the last word, and outReq and outValid are never high together.
- R5: A wrStop pulse during a message discards every word of that message, so it is never delivered.
- R6: outAbort in a cycle with outValid high ends the burst in the next cycle and rewinds the read side. The complete packet is then requested and sent again from its first word.
- R7: If a message in progress sees no wrValid for TIMEOUT consecutive cycles, it is discarded and the write side returns to idle. Words without a start strobe that arrive later are ignored.
- R8: If outReq sees no grant for TIMEOUT consecutive cycles, it drops for exactly one cycle and is then raised again. The stored packet is unchanged.
- R9: A message that does not fit in the free space, CRC word included, is dropped entirely. Messages committed earlier are still delivered intact.
- R10: Messages are delivered in the order they were completed, also while writing and reading run at the same time.
- R11: The cycle after an end word is reserved for the CRC. A start word driven in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrValid | input | 1 | Input word valid |
| wrStart | input | 1 | Marks the first word of a message |
| wrEnd | input | 1 | Marks the last word of a message |
| wrStop | input | 1 | Abandons the message being written |
| wrData | input | 16 | Input word |
| outGrant | input | 1 | One-cycle grant from the arbiter |
| outAbort | input | 1 | Cancels the current burst for a later resend |
| outReq | output | 1 | A complete message waits for the link |
| outValid | output | 1 | Output word valid |
| outLast | output | 1 | Output word is the CRC word |
| outData | output | 16 | Output word |

## Verification
The collision that matters is a write commit and a read commit landing on the same clock edge. One message becomes complete while another leaves, and the stored-message count must both rise and fall in that edge. The random phase provokes this by streaming short messages with small gaps while grants arrive at random and bursts are sometimes aborted, so end words and last words often fall in the same cycle. Every delivered packet is compared word by word against an in-order queue built from the bench's own CRC model. A lost or duplicated message at such a collision therefore shows up as a mismatch, an unexpected packet or a message left undelivered.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [DATA_W-1:0] CRC_SEED = 16'hFFFF;

  // strobes from control to datapath
  typedef struct packed {
    logic push;        // store a message word
    logic pushCrc;     // store the checksum word
    logic crcInit;     // push is the first word of a message
    logic wrCommit;    // expose the written message to the reader
    logic wrRollback;  // drop the uncommitted words
    logic pop;         // advance tentative read pointer
    logic rdCommit;    // release the sent message
    logic rdRollback;  // rewind to the last released position
  } bufCtl_t;

  function automatic logic [DATA_W-1:0] crcAdvance(
      input logic [DATA_W-1:0] acc, input logic [DATA_W-1:0] word);
    logic [DATA_W-1:0] r;
    r = acc;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (r[DATA_W-1] ^ word[i]) r = (r << 1) ^ CRC_POLY;
      else r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/txbuf_watchdog.sv
module txbuf_watchdog #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic kick,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] idleCnt;

  assign fire = armed && !kick && (idleCnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !armed || kick || fire) idleCnt <= '0;
    else idleCnt <= idleCnt + CW'(1);
  end
endmodule

// File: rtl/txbuf_datapath.sv
module txbuf_datapath
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  bufCtl_t           ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  output logic              msgAvail,
  output logic [DATA_W:0]   rdWord
);
  localparam int AW = $clog2(DEPTH);
  typedef logic [AW:0] ptr_t;
  localparam ptr_t ONE = ptr_t'(1);
  localparam ptr_t CAP = ptr_t'(DEPTH);

  logic [DATA_W:0]   mem [DEPTH];
  ptr_t              wrPtr, wrSafe, rdPtr, rdSafe, msgCount;
  logic [DATA_W-1:0] crcAcc;

  assign full     = (ptr_t'(wrPtr - rdSafe) == CAP);
  assign msgAvail = (msgCount != '0);
  assign rdWord   = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (ctl.push)         mem[wrPtr[AW-1:0]] <= {1'b0, wrData};
    else if (ctl.pushCrc) mem[wrPtr[AW-1:0]] <= {1'b1, crcAcc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      wrSafe   <= '0;
      rdPtr    <= '0;
      rdSafe   <= '0;
      msgCount <= '0;
      crcAcc   <= CRC_SEED;
    end else begin
      if (ctl.wrRollback) wrPtr <= wrSafe;
      else if (ctl.push || ctl.pushCrc) wrPtr <= wrPtr + ONE;
      if (ctl.wrCommit) wrSafe <= wrPtr + ONE;
      if (ctl.push) crcAcc <= crcAdvance(ctl.crcInit ? CRC_SEED : crcAcc, wrData);

      if (ctl.rdRollback) rdPtr <= rdSafe;
      else if (ctl.pop) rdPtr <= rdPtr + ONE;
      if (ctl.rdCommit) rdSafe <= rdPtr + ONE;

      unique case ({ctl.wrCommit, ctl.rdCommit})
        2'b10:   msgCount <= msgCount + ONE;
        2'b01:   msgCount <= msgCount - ONE;
        default: msgCount <= msgCount;
      endcase
    end
  end
endmodule

// File: rtl/txbuf_control.sv
module txbuf_control
  import txbuf_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    wrValid,
  input  logic    wrStart,
  input  logic    wrEnd,
  input  logic    wrStop,
  input  logic    full,
  input  logic    msgAvail,
  input  logic    rdLast,
  input  logic    outGrant,
  input  logic    outAbort,
  output bufCtl_t ctl,
  output logic    outReq,
  output logic    outValid
);
  typedef enum logic [1:0] {W_IDLE, W_BODY, W_CRC, W_DROP} wState_t;
  typedef enum logic [1:0] {R_IDLE, R_REQ, R_SEND} rState_t;

  wState_t wState, wNext;
  rState_t rState, rNext;
  logic    wFire, rFire;

  txbuf_watchdog #(.LIMIT(TIMEOUT)) u_wrDog (
    .clk(clk), .rst(rst), .armed(wState != W_IDLE), .kick(wrValid), .fire(wFire));
  txbuf_watchdog #(.LIMIT(TIMEOUT)) u_rdDog (
    .clk(clk), .rst(rst), .armed(rState == R_REQ), .kick(outGrant), .fire(rFire));

  always_comb begin
    ctl   = '0;
    wNext = wState;
    unique case (wState)
      W_IDLE:
        if (wrValid && wrStart && !wrStop) begin
          if (full) wNext = wrEnd ? W_IDLE : W_DROP;
          else begin
            ctl.push    = 1'b1;
            ctl.crcInit = 1'b1;
            wNext       = wrEnd ? W_CRC : W_BODY;
          end
        end
      W_BODY:
        if (wrStop || wFire) begin
          ctl.wrRollback = 1'b1;
          wNext          = W_IDLE;
        end else if (wrValid) begin
          if (full) begin
            ctl.wrRollback = 1'b1;
            wNext          = wrEnd ? W_IDLE : W_DROP;
          end else begin
            ctl.push = 1'b1;
            if (wrEnd) wNext = W_CRC;
          end
        end
      W_CRC: begin
        if (wrStop || full) ctl.wrRollback = 1'b1;
        else begin
          ctl.pushCrc  = 1'b1;
          ctl.wrCommit = 1'b1;
        end
        wNext = W_IDLE;
      end
      W_DROP:
        if (wrStop || wFire || (wrValid && wrEnd)) wNext = W_IDLE;
      default: wNext = W_IDLE;
    endcase

    rNext = rState;
    unique case (rState)
      R_IDLE: if (msgAvail) rNext = R_REQ;
      R_REQ:
        if (outGrant) rNext = R_SEND;
        else if (rFire) rNext = R_IDLE;
      R_SEND:
        if (outAbort) begin
          ctl.rdRollback = 1'b1;
          rNext          = R_IDLE;
        end else begin
          ctl.pop = 1'b1;
          if (rdLast) begin
            ctl.rdCommit = 1'b1;
            rNext        = R_IDLE;
          end
        end
      default: rNext = R_IDLE;
    endcase
  end

  assign outReq   = (rState == R_REQ);
  assign outValid = (rState == R_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      wState <= W_IDLE;
      rState <= R_IDLE;
    end else begin
      wState <= wNext;
      rState <= rNext;
    end
  end
endmodule

// File: rtl/hardened_tx_buffer.sv
module hardened_tx_buffer
  import txbuf_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrValid,
  input  logic              wrStart,
  input  logic              wrEnd,
  input  logic              wrStop,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outGrant,
  input  logic              outAbort,
  output logic              outReq,
  output logic              outValid,
  output logic              outLast,
  output logic [DATA_W-1:0] outData
);
  bufCtl_t         ctl;
  logic            full, msgAvail;
  logic [DATA_W:0] rdWord;

  txbuf_control #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrStart(wrStart), .wrEnd(wrEnd),
    .wrStop(wrStop), .full(full), .msgAvail(msgAvail), .rdLast(rdWord[DATA_W]),
    .outGrant(outGrant), .outAbort(outAbort), .ctl(ctl), .outReq(outReq),
    .outValid(outValid));

  txbuf_datapath #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .ctl(ctl), .wrData(wrData), .full(full),
    .msgAvail(msgAvail), .rdWord(rdWord));

  assign outLast = outValid && rdWord[DATA_W];
  assign outData = outValid ? rdWord[DATA_W-1:0] : '0;
endmodule

// File: rtl/txbuf_checker.sv
module txbuf_checker (
  input logic clk,
  input logic rst,
  input logic outReq,
  input logic outValid,
  input logic outLast,
  input logic outGrant,
  input logic outAbort
);
  // R4
  grant_starts_send_chk: assert property (@(posedge clk) disable iff (rst)
    (outReq && outGrant) |=> outValid);
  // R4
  burst_contiguous_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outLast && !outAbort) |=> outValid);
  // R4
  burst_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outLast && !outAbort) |=> !outValid);
  // R4
  req_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({outReq, outValid}));
  // R6
  abort_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outAbort) |=> !outValid);
  // R2
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);
endmodule

bind hardened_tx_buffer txbuf_checker u_chk (
  .clk(clk), .rst(rst), .outReq(outReq), .outValid(outValid),
  .outLast(outLast), .outGrant(outGrant), .outAbort(outAbort));

// File: tb/sim_hardened_tx_buffer.sv
module sim_hardened_tx_buffer;
  localparam int DEPTH = 32;
  localparam int TMO   = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic wrValid = 0, wrStart = 0, wrEnd = 0, wrStop = 0;
  logic [15:0] wrData = '0;
  logic outGrant, outAbort, outReq, outValid, outLast;
  logic [15:0] outData;

  int nChecks = 0, nFails = 0;
  logic [16:0] expQ[$];
  int idx = 0, nMsgs = 0, nAborts = 0, written = 0, delivered = 0;
  bit grantEn = 0, abortEn = 0, msgBad = 0, done = 0;
  int forceAbortAt = -1;
  bit prevGrant = 0, prevValid = 0, prevLast = 0, prevAbort = 0;
  logic [15:0] buffer[0:15];

  always #4 clk = ~clk;

  hardened_tx_buffer #(.DEPTH(DEPTH), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrStart(wrStart), .wrEnd(wrEnd),
    .wrStop(wrStop), .wrData(wrData), .outGrant(outGrant), .outAbort(outAbort),
    .outReq(outReq), .outValid(outValid), .outLast(outLast), .outData(outData));

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [15:0] d);
    logic fb;
    for (int b = 15; b >= 0; b--) begin
      fb = c[15] ^ d[b];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit s, input bit e, input bit st, input logic [15:0] d);
    @(negedge clk);
    wrValid = v; wrStart = s; wrEnd = e; wrStop = st; wrData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, '0);
  endtask

  // sends len words; keep: expected to be delivered; tail: start word in CRC cycle
  task automatic sendMsg(input int len, input bit keep, input int maxGap, input bit tail);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      buffer[i] = 16'($urandom);
      c = refCrc(c, buffer[i]);
    end
    if (keep) begin
      for (int i = 0; i < len; i++) expQ.push_back({1'b0, buffer[i]});
      expQ.push_back({1'b1, c});
      written += len + 1;
    end
    for (int i = 0; i < len; i++) begin
      if (i > 0 && maxGap > 0) idle($urandom % (maxGap + 1));
      drive(1, i == 0, i == len - 1, 0, buffer[i]);
    end
    if (tail) drive(1, 1, 1, 0, 16'hBEEF);
    else drive(0, 0, 0, 0, '0);
    drive(0, 0, 0, 0, '0);
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 3000 && !(expQ.size() == 0 && !outValid && !outReq); i++)
      @(negedge clk);
    check(expQ.size() == 0, "R10 drain", expQ.size(), 0);
  endtask

  // output side: grant, abort and scoreboard
  initial begin
    bit g, ab;
    outGrant = 0; outAbort = 0;
    forever begin
      @(negedge clk);
      if (rst) continue;
      if (outValid && !(prevGrant || (prevValid && !prevLast && !prevAbort)))
        check(0, "R4 burst not contiguous after grant", 0, 1);
      ab = outValid && ((abortEn && ($urandom % 10 == 0)) || idx == forceAbortAt);
      if (ab && idx == forceAbortAt) forceAbortAt = -1;
      g = outReq && grantEn && ($urandom % 3 == 0);
      outAbort = ab; outGrant = g;
      if (outValid && ab) begin
        idx = 0; msgBad = 0; nAborts++;
      end else if (outValid) begin
        if (idx >= expQ.size()) begin
          if (!msgBad) check(0, "R2 unexpected word", {outLast, outData}, -1);
          msgBad = 1;
        end else if ({outLast, outData} !== expQ[idx] && !msgBad) begin
          check(0, "R2 word mismatch", {outLast, outData}, expQ[idx]);
          msgBad = 1;
        end
        idx++;
        if (outLast) begin
          if (!msgBad) check(1, "R2", 0, 0);
          for (int i = 0; i < idx && expQ.size() > 0; i++) void'(expQ.pop_front());
          delivered += idx;
          idx = 0; msgBad = 0; nMsgs++;
        end
      end
      prevGrant = g && outReq; prevValid = outValid; prevLast = outLast; prevAbort = ab;
    end
  end

  initial begin
    #(8 * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int base, hi, lo, abBase;
    void'($urandom(32'd4711));
    idle(4);
    rst = 0;
    @(negedge clk);
    check(!outReq && !outValid, "R1 reset outputs", {outReq, outValid}, 0);

    // R3: no request during write, request soon after
    grantEn = 0;
    fork
      begin sendMsg(5, 1, 2, 0); done = 1; end
      begin
        hi = 0;
        while (!done) begin @(negedge clk); if (!done && outReq) hi++; end
      end
    join
    done = 0;
    check(hi == 0, "R3 request during write", hi, 0);
    idle(2);
    check(outReq == 1, "R3 request after commit", outReq, 1);

    // R8: ungranted request drops after TMO cycles for one cycle
    while (outReq) @(negedge clk);
    while (!outReq) @(negedge clk);
    hi = 0; while (outReq) begin hi++; @(negedge clk); end
    lo = 0; while (!outReq) begin lo++; @(negedge clk); end
    check(hi == TMO, "R8 request length", hi, TMO);
    check(lo == 1, "R8 request gap", lo, 1);
    grantEn = 1;
    waitDrain();
    check(nMsgs == 1, "R8 packet delivered after retry", nMsgs, 1);

    // R5: stop discards
    base = nMsgs;
    drive(1, 1, 0, 0, 16'h1111); drive(1, 0, 0, 0, 16'h2222); drive(0, 0, 0, 1, '0);
    idle(1);
    sendMsg(3, 1, 0, 0);
    waitDrain();
    check(nMsgs - base == 1, "R5 stopped message discarded", nMsgs - base, 1);

    // R7: write watchdog
    base = nMsgs;
    drive(1, 1, 0, 0, 16'h3333); drive(1, 0, 0, 0, 16'h4444);
    idle(TMO + 3);
    drive(1, 0, 1, 0, 16'h5555);
    idle(2);
    check(!outReq && !outValid, "R7 stalled message not offered", {outReq, outValid}, 0);
    sendMsg(2, 1, 0, 0);
    waitDrain();
    check(nMsgs - base == 1, "R7 timed-out message discarded", nMsgs - base, 1);

    // R11: start in the CRC cycle ignored
    base = nMsgs;
    sendMsg(3, 1, 0, 1);
    waitDrain();
    check(nMsgs - base == 1, "R11 CRC-cycle start ignored", nMsgs - base, 1);

    // R9: overflow drops only the new message
    base = nMsgs; grantEn = 0;
    for (int m = 0; m < 4; m++) sendMsg(7, 1, 0, 0);
    sendMsg(3, 0, 0, 0);
    grantEn = 1;
    waitDrain();
    check(nMsgs - base == 4, "R9 stored messages kept", nMsgs - base, 4);
    written = 0; delivered = 0;

    // R6: forced abort mid-burst, then resend
    base = nMsgs; abBase = nAborts; forceAbortAt = 2;
    sendMsg(6, 1, 0, 0);
    waitDrain();
    check(nAborts - abBase == 1, "R6 abort taken", nAborts - abBase, 1);
    check(nMsgs - base == 1, "R6 packet resent whole", nMsgs - base, 1);

    // R10: random concurrent traffic with aborts
    base = nMsgs; abortEn = 1;
    for (int m = 0; m < 60; m++) begin
      int len;
      len = 1 + $urandom % 8;
      while (written - delivered + len + 1 > DEPTH) @(negedge clk);
      sendMsg(len, 1, $urandom % 3, 0);
      if ($urandom % 4 == 0) idle($urandom % 4);
    end
    waitDrain();
    abortEn = 0;
    check(nMsgs - base == 60, "R10 all messages in order", nMsgs - base, 60);
    check(nAborts > abBase + 1, "R6 random aborts seen", nAborts, abBase + 2);

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule